// File: doc/BRIEF.md
# Synchronous SRAM Write-Cycle Controller

This block sits at the front of a pipelined synchronous SRAM whose shared data bus is 18 bits wide: two byte lanes of eight data bits, each with its own parity bit. On every rising clock edge it samples three chip selects, two address strobes, a global write input, a lane-write enable and one lane-select bit per byte lane. From these it decides whether a write cycle starts, a read cycle starts, or nothing happens. It then writes the selected lanes of a small internal array and controls when the shared bus may be driven.

A write cycle stores the bus contents into the addressed word. Only the enabled lanes are stored, and each lane's parity bit goes with its data byte. A read cycle registers the addressed word one clock after the address is taken. The bus is driven only while that registered read is valid and the asynchronous output enable is low. As soon as a write is seen at the inputs, the driver is shut off, whatever the output enable says. The captured cycle address and the cycle type are given on registered outputs for the burst-address logic.

Top module: `sram_wr_ctrl`

## Requirements
- R1: While `rst` is high, and at the first edge after it is asserted, `cyc_write` and `cyc_read` are 0, and `bus_drive` is 0 even when `out_en_n` is low.
- R2: A cycle is taken only when `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0, `ctl_strobe_n`=0 and `proc_strobe_n`=1. It is a write when at least one lane is enabled. `cyc_write` is 1 for the cycle that follows the edge.
- R3: When `proc_strobe_n` is 0, `ctl_strobe_n` is ignored. No cycle starts and the array is not changed.
- R4: When a cycle starts, `addr` is captured and shown on `cyc_addr` after the edge.
- R5: `wr_all_n`=0 enables both lanes, whatever `lane_wr_n` and `lane_sel_n` are.
- R6: With `wr_all_n`=1 and `lane_wr_n`=0, lane k is written only if `lane_sel_n[k]`=0. Lane 0 is `bus_in[7:0]` with parity `bus_in[16]`. Lane 1 is `bus_in[15:8]` with parity `bus_in[17]`.
- R7: With the strobe conditions of R2 and no lane enabled, a read starts. After the edge, `cyc_read`=1 and `bus_out` holds the addressed word in the same bit layout.
- R8: `bus_drive` is 1 only when `cyc_read` is 1, `out_en_n` is 0 and no write is detected. It follows `out_en_n` without waiting for a clock edge.
- R9: While a write is detected at the inputs, `bus_drive` is 0. This holds for a partial lane write and with `out_en_n` low.
- R10: If any chip select is inactive, no cycle starts and the array is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low, has priority |
| wr_all_n | input | 1 | Global write, all lanes, active low |
| lane_wr_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| bus_in | input | 18 | Data and parity seen on the shared bus |
| bus_out | output | 18 | Read data for the shared bus |
| bus_drive | output | 1 | Bus driver enable |
| cyc_write | output | 1 | A write cycle started at the last edge |
| cyc_read | output | 1 | A read cycle started at the last edge |
| cyc_addr | output | ADDR_W | Captured cycle address |

## Verification
On every cycle, the assertions check four things: the driver is never on during a detected write or outside a registered read, a held-off or deselected strobe leaves both cycle flags low, and a cycle start always loads the address register. Only the bench scenarios can show the array contents. These cover lane gating with parity, the global write overriding the lane selects, and writes that were ignored leaving the stored word unchanged, all seen through later reads. The bench also shows the driver following the output enable between clock edges.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  // kind of cycle accepted at the last clock edge
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_WRITE = 2'd1,
    CYC_READ  = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              ctl_strobe_n,
  input  logic              proc_strobe_n,
  input  logic              wr_all_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  lane_we,
  output logic              wr_go,
  output logic              rd_go,
  output logic              cyc_write,
  output logic              cyc_read,
  output logic [ADDR_W-1:0] cyc_addr
);
  logic      chip_sel;
  logic      strobe_ok;
  cyc_kind_e cyc_q;

  assign chip_sel  = !sel_a_n && sel_b && !sel_c_n;
  // the processor strobe wins: an active one masks the controller strobe
  assign strobe_ok = proc_strobe_n && !ctl_strobe_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = chip_sel && strobe_ok &&
                        (!wr_all_n || (!lane_wr_n && !lane_sel_n[g]));
  end

  assign wr_go = |lane_we;
  assign rd_go = chip_sel && strobe_ok && !wr_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q    <= CYC_IDLE;
      cyc_addr <= '0;
    end else begin
      if (wr_go)      cyc_q <= CYC_WRITE;
      else if (rd_go) cyc_q <= CYC_READ;
      else            cyc_q <= CYC_IDLE;
      if (wr_go || rd_go) cyc_addr <= addr;
    end
  end

  assign cyc_write = (cyc_q == CYC_WRITE);
  assign cyc_read  = (cyc_q == CYC_READ);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!cyc_write && !cyc_read));
  assert_write_flag_R2: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> cyc_write);
  assert_strobe_priority_R3: assert property (@(posedge clk) disable iff (rst)
    !proc_strobe_n |=> (!cyc_write && !cyc_read));
  assert_addr_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_go || rd_go) |=> (cyc_addr == $past(addr)));
  assert_read_flag_R7: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> cyc_read);
  assert_deselect_R10: assert property (@(posedge clk) disable iff (rst)
    (sel_a_n || !sel_b || sel_c_n) |=> (!cyc_write && !cyc_read));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_go,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // one simple dual-use memory per lane so each maps onto its own RAM slice
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_go)      rd_q      <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_bus_out.sv
module sram_bus_out #(
  parameter int LANES     = 2,
  parameter int LANE_DATA = 8
) (
  input  logic                                cyc_read,
  input  logic                                out_en_n,
  input  logic                                wr_go,
  input  logic [LANES*(LANE_DATA+1)-1:0]      lane_rdata,
  output logic [LANES*(LANE_DATA+1)-1:0]      bus_out,
  output logic                                bus_drive
);
  localparam int LANE_W = LANE_DATA + 1;
  localparam int PAR_LO = LANES * LANE_DATA;

  // lane word is {parity, data}; the bus puts all data low, parity on top
  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign bus_out[g*LANE_DATA +: LANE_DATA] = lane_rdata[g*LANE_W +: LANE_DATA];
    assign bus_out[PAR_LO + g]               = lane_rdata[g*LANE_W + LANE_DATA];
  end

  // asynchronous enable, overridden by any detected write
  assign bus_drive = cyc_read && !out_en_n && !wr_go;
endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl #(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 2,
  parameter int LANE_DATA = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               sel_a_n,
  input  logic                               sel_b,
  input  logic                               sel_c_n,
  input  logic                               ctl_strobe_n,
  input  logic                               proc_strobe_n,
  input  logic                               wr_all_n,
  input  logic                               lane_wr_n,
  input  logic [LANES-1:0]                   lane_sel_n,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               out_en_n,
  input  logic [LANES*(LANE_DATA+1)-1:0]     bus_in,
  output logic [LANES*(LANE_DATA+1)-1:0]     bus_out,
  output logic                               bus_drive,
  output logic                               cyc_write,
  output logic                               cyc_read,
  output logic [ADDR_W-1:0]                  cyc_addr
);
  localparam int LANE_W = LANE_DATA + 1;
  localparam int BUS_W  = LANES * LANE_W;
  localparam int PAR_LO = LANES * LANE_DATA;

  logic [LANES-1:0] lane_we;
  logic             wr_go;
  logic             rd_go;
  logic [BUS_W-1:0] lane_wdata;
  logic [BUS_W-1:0] lane_rdata;

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign lane_wdata[g*LANE_W +: LANE_W] =
      {bus_in[PAR_LO + g], bus_in[g*LANE_DATA +: LANE_DATA]};
  end

  sram_cycle_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_decode (
    .clk           (clk),
    .rst           (rst),
    .sel_a_n       (sel_a_n),
    .sel_b         (sel_b),
    .sel_c_n       (sel_c_n),
    .ctl_strobe_n  (ctl_strobe_n),
    .proc_strobe_n (proc_strobe_n),
    .wr_all_n      (wr_all_n),
    .lane_wr_n     (lane_wr_n),
    .lane_sel_n    (lane_sel_n),
    .addr          (addr),
    .lane_we       (lane_we),
    .wr_go         (wr_go),
    .rd_go         (rd_go),
    .cyc_write     (cyc_write),
    .cyc_read      (cyc_read),
    .cyc_addr      (cyc_addr)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .lane_we (lane_we),
    .rd_go   (rd_go),
    .addr    (addr),
    .wdata   (lane_wdata),
    .rdata   (lane_rdata)
  );

  sram_bus_out #(.LANES(LANES), .LANE_DATA(LANE_DATA)) u_bus (
    .cyc_read   (cyc_read),
    .out_en_n   (out_en_n),
    .wr_go      (wr_go),
    .lane_rdata (lane_rdata),
    .bus_out    (bus_out),
    .bus_drive  (bus_drive)
  );

  assert_tristate_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> !bus_drive);
  assert_drive_only_read_R8: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> (cyc_read && !out_en_n));
endmodule

// File: tb/sram_wr_ctrl_test.sv
`timescale 1ns/1ps
module sram_wr_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        sel_a_n, sel_b, sel_c_n, ctl_strobe_n, proc_strobe_n;
  logic        wr_all_n, lane_wr_n;
  logic [1:0]  lane_sel_n;
  logic [5:0]  addr;
  logic        out_en_n;
  logic [17:0] bus_in;
  logic [17:0] bus_out;
  logic        bus_drive, cyc_write, cyc_read;
  logic [5:0]  cyc_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sram_wr_ctrl uut (
    .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .ctl_strobe_n(ctl_strobe_n), .proc_strobe_n(proc_strobe_n),
    .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .addr(addr), .out_en_n(out_en_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_drive(bus_drive), .cyc_write(cyc_write), .cyc_read(cyc_read),
    .cyc_addr(cyc_addr)
  );

  // control field: {sel_a_n, sel_b, sel_c_n, ctl_strobe_n, proc_strobe_n,
  //                 wr_all_n, lane_wr_n, lane_sel_n[1:0]}
  localparam logic [8:0] IDLE  = 9'b0_1_0_1_1_1_1_11;
  localparam logic [8:0] RDCTL = 9'b0_1_0_0_1_1_1_11;
  localparam int NV = 13;
  // vector: {control, addr, bus_in, expected {cyc_write, cyc_read}}
  localparam logic [34:0] VEC [NV] = '{
    {9'b0_1_0_0_1_0_1_11, 6'd7,  18'h00F0F, 2'b10},  // R2 R5 full write
    {9'b0_1_0_0_1_0_1_11, 6'd5,  18'h2A5A5, 2'b10},  // R2 full write
    {9'b0_1_0_0_1_1_0_10, 6'd6,  18'h13C3C, 2'b10},  // R6 lane 0 only
    {9'b0_1_0_0_1_1_0_01, 6'd6,  18'h2A5FF, 2'b10},  // R6 lane 1 only
    {9'b0_1_0_0_0_0_1_11, 6'd7,  18'h3FFFF, 2'b00},  // R3 processor strobe masks
    {9'b1_1_0_0_1_0_1_11, 6'd7,  18'h3FFFF, 2'b00},  // R10 select A off
    {9'b0_0_0_0_1_0_1_11, 6'd7,  18'h3FFFF, 2'b00},  // R10 select B off
    {9'b0_1_1_0_1_0_1_11, 6'd7,  18'h3FFFF, 2'b00},  // R10 select C off
    {9'b0_1_0_1_1_0_1_11, 6'd7,  18'h3FFFF, 2'b00},  // R2 no strobe
    {9'b0_1_0_0_1_1_0_11, 6'd7,  18'h3FFFF, 2'b01},  // R7 no lane selected
    {9'b0_1_0_0_1_0_0_00, 6'd9,  18'h01234, 2'b10},  // R5 global write
    {9'b0_1_0_0_1_1_1_00, 6'd6,  18'h3FFFF, 2'b01},  // R7 lane selects ignored
    {9'b0_1_0_0_1_0_1_11, 6'd63, 18'h3FFFF, 2'b10}   // R4 top address
  };

  task automatic apply(input logic [8:0] c, input logic [5:0] a, input logic [17:0] d);
    {sel_a_n, sel_b, sel_c_n, ctl_strobe_n, proc_strobe_n,
     wr_all_n, lane_wr_n, lane_sel_n} = c;
    addr   = a;
    bus_in = d;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [5:0] a, input logic [17:0] exp, input string req);
    out_en_n = 1'b1;
    apply(RDCTL, a, 18'h0);
    step();
    apply(IDLE, 6'd0, 18'h0);
    chk({req, " read flag"}, {31'd0, cyc_read}, 32'd1);
    chk("R8 drive off with enable high", {31'd0, bus_drive}, 32'd0);
    out_en_n = 1'b0;
    #1;
    chk("R8 drive follows enable", {31'd0, bus_drive}, 32'd1);
    chk({req, " read data"}, {14'd0, bus_out}, {14'd0, exp});
    out_en_n = 1'b1;
    #1;
  endtask

  initial begin
    rst      = 1'b1;
    out_en_n = 1'b0;
    apply(IDLE, 6'd0, 18'h0);
    step();
    step();
    chk("R1 write flag in reset", {31'd0, cyc_write}, 32'd0);
    chk("R1 read flag in reset", {31'd0, cyc_read}, 32'd0);
    chk("R1 bus off in reset", {31'd0, bus_drive}, 32'd0);
    rst      = 1'b0;
    out_en_n = 1'b1;
    step();

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][34:26], VEC[v][25:20], VEC[v][19:2]);
      step();
      chk($sformatf("R2/R3/R10 write flag vector %0d", v), {31'd0, cyc_write}, {31'd0, VEC[v][1]});
      chk($sformatf("R7 read flag vector %0d", v), {31'd0, cyc_read}, {31'd0, VEC[v][0]});
      if (VEC[v][1:0] != 2'b00)
        chk($sformatf("R4 address vector %0d", v), {26'd0, cyc_addr}, {26'd0, VEC[v][25:20]});
    end
    apply(IDLE, 6'd0, 18'h0);
    step();

    read_chk(6'd7,  18'h00F0F, "R3");
    read_chk(6'd7,  18'h00F0F, "R10");
    read_chk(6'd6,  18'h3A53C, "R6");
    read_chk(6'd5,  18'h2A5A5, "R7");
    read_chk(6'd9,  18'h01234, "R5");
    read_chk(6'd63, 18'h3FFFF, "R2");

    // R9: a write seen at the inputs shuts the driver off at once
    apply(RDCTL, 6'd5, 18'h0);
    step();
    apply(IDLE, 6'd0, 18'h0);
    out_en_n = 1'b0;
    #1;
    chk("R9 drive before write", {31'd0, bus_drive}, 32'd1);
    apply(9'b0_1_0_0_1_1_0_10, 6'd20, 18'h0);
    #1;
    chk("R9 partial write forces off", {31'd0, bus_drive}, 32'd0);
    apply(9'b0_1_0_0_1_0_1_11, 6'd20, 18'h0);
    #1;
    chk("R9 full write forces off", {31'd0, bus_drive}, 32'd0);
    apply(IDLE, 6'd0, 18'h0);
    #1;
    chk("R9 drive back after write leaves", {31'd0, bus_drive}, 32'd1);
    step();
    chk("R8 no drive without read", {31'd0, bus_drive}, 32'd0);
    out_en_n = 1'b1;

    // R1: reset in the middle of a read output
    apply(RDCTL, 6'd5, 18'h0);
    step();
    apply(IDLE, 6'd0, 18'h0);
    out_en_n = 1'b0;
    rst      = 1'b1;
    step();
    chk("R1 read flag cleared", {31'd0, cyc_read}, 32'd0);
    chk("R1 bus off after reset", {31'd0, bus_drive}, 32'd0);
    rst      = 1'b0;
    out_en_n = 1'b1;
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule